// File: doc/BRIEF.md
# Glitch-Balanced Masked Field Multiplier

This block multiplies two secret values that arrive only in Boolean-masked form. Each operand comes as a masked share together with its mask. The true operands are `a = am ^ ma` and `b = bm ^ mb`. The block returns the product `a·b` in GF(2^W), re-masked by a fresh mask `mq`, so the unmasked product never appears on any wire. With `W = 1` it is a masked AND gate. With `W = 4` it is the subfield multiplier of a composite-field S-box, reducing by x^4 + x + 1.

The datapath is split into two register stages so that every XOR tree sees all of its inputs change at one instant:

- **First stage.** A rising-edge bank captures all five inputs together. Five partial products are formed from these registers: am·bm, bm·ma, am·mb, ma·mb and mq·1.
- **Balanced tree.** The last four partial products are folded by a two-level XOR tree into one term.
- **Second stage.** That term and the am·bm product have unequal path depths, so both are captured by falling-edge flops. A single XOR then forms the output.

A result therefore appears half a clock after the operands are captured. A valid flag travels alongside the data.

Top module: `masked_gf_mult`

## Requirements
- R1: After capture, `qm` equals `((am^ma)·(bm^mb)) ^ mq`, where `·` is multiplication in GF(2^W) modulo x^4+x+1 for the default W = 4 (bitwise AND when W = 1).
- R2: Operands present at a rising edge reach `qm` at the next falling edge and stay there until the falling edge after it. Input changes made after a rising edge leave `qm` untouched until they are captured.
- R3: `out_valid` reproduces `in_valid` with the same timing as R2.
- R4: Reset is synchronous and active high. A rising edge with `rst` high clears the input stage, and a falling edge with `rst` high clears the output stage, leaving `qm = 0` and `out_valid = 0`.
- R5: Two operand sets that encode the same `a` and `b` under different input masks give the same `qm ^ mq`.
- R6: When the true operand `a` is zero (`am == ma`), `qm` equals `mq`.
- R7: When the true operand `a` is one, `qm` equals `b ^ mq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; input stage on rising edge, output stage on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand set as meaningful |
| am | input | W | Masked share of operand a |
| ma | input | W | Mask of operand a |
| bm | input | W | Masked share of operand b |
| mb | input | W | Mask of operand b |
| mq | input | W | Fresh mask applied to the product |
| out_valid | output | 1 | Delayed copy of in_valid |
| qm | output | W | Product masked by mq |

## Verification
In every clock period the rising edge captures a new operand set while `qm` still shows the previous product. The falling edge then replaces that product. The bench provokes this overlap by changing all inputs right after each capture. Just after the rising edge it confirms that `qm` still holds the old result (R2). After the falling edge it compares the new result with a carry-less multiply-and-reduce model. A reset raised mid-stream must win over that same handover and zero the output at the falling edge.

// File: rtl/mgm_pkg.sv
`timescale 1ns/1ps
package mgm_pkg;

    localparam int MAX_W = 8;

    // Shift-and-add multiply in GF(2^w); poly carries the reduction terms.
    function automatic logic [MAX_W-1:0] gf_mul(input logic [MAX_W-1:0] x,
                                                input logic [MAX_W-1:0] y,
                                                input logic [MAX_W:0]   poly,
                                                input int               w);
        logic [MAX_W-1:0] acc;
        logic [MAX_W-1:0] sh;
        logic [MAX_W-1:0] msk;
        logic             carry;
        msk = MAX_W'((9'd1 << w) - 9'd1);
        acc = '0;
        sh  = x & msk;
        for (int k = 0; k < MAX_W; k++) begin
            if (k < w) begin
                if (y[k]) acc = acc ^ sh;
                carry = sh[w-1];
                sh    = (sh << 1) & msk;
                if (carry) sh = sh ^ (poly[MAX_W-1:0] & msk);
            end
        end
        return acc;
    endfunction

    typedef enum logic [2:0] {
        PP_AB  = 3'd0,
        PP_BMA = 3'd1,
        PP_AMB = 3'd2,
        PP_MM  = 3'd3,
        PP_Q1  = 3'd4
    } pp_idx_e;

    localparam int NUM_PP = 5;

endpackage

// File: rtl/mm_gf_mul.sv
`timescale 1ns/1ps
module mm_gf_mul import mgm_pkg::*; #(
    parameter int             W    = 4,
    parameter logic [MAX_W:0] POLY = 9'h013
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] p
);
    generate
        if (W == 1) begin : g_and
            assign p = x & y;
        end else begin : g_field
            logic [MAX_W-1:0] full;
            assign full = gf_mul(MAX_W'(x), MAX_W'(y), POLY, W);
            assign p    = full[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mm_in_stage.sv
`timescale 1ns/1ps
module mm_in_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] am_i,
    input  logic [W-1:0] ma_i,
    input  logic [W-1:0] bm_i,
    input  logic [W-1:0] mb_i,
    input  logic [W-1:0] mq_i,
    output logic         vld_o,
    output logic [W-1:0] am_o,
    output logic [W-1:0] ma_o,
    output logic [W-1:0] bm_o,
    output logic [W-1:0] mb_o,
    output logic [W-1:0] mq_o
);
    // All five shares update on one edge so downstream gates switch together.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            am_o  <= '0;
            ma_o  <= '0;
            bm_o  <= '0;
            mb_o  <= '0;
            mq_o  <= '0;
        end else begin
            vld_o <= vld_i;
            am_o  <= am_i;
            ma_o  <= ma_i;
            bm_o  <= bm_i;
            mb_o  <= mb_i;
            mq_o  <= mq_i;
        end
    end
endmodule

// File: rtl/mm_pp_tree.sv
`timescale 1ns/1ps
module mm_pp_tree import mgm_pkg::*; #(
    parameter int             W    = 4,
    parameter logic [MAX_W:0] POLY = 9'h013
) (
    input  logic [W-1:0] am,
    input  logic [W-1:0] ma,
    input  logic [W-1:0] bm,
    input  logic [W-1:0] mb,
    input  logic [W-1:0] mq,
    output logic [W-1:0] t_direct,
    output logic [W-1:0] t_folded
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] lhs [NUM_PP];
    logic [W-1:0] rhs [NUM_PP];
    logic [W-1:0] pp  [NUM_PP];

    always_comb begin
        lhs[PP_AB]  = am;  rhs[PP_AB]  = bm;
        lhs[PP_BMA] = bm;  rhs[PP_BMA] = ma;
        lhs[PP_AMB] = am;  rhs[PP_AMB] = mb;
        lhs[PP_MM]  = ma;  rhs[PP_MM]  = mb;
        lhs[PP_Q1]  = mq;  rhs[PP_Q1]  = ONE;
    end

    generate
        for (genvar g = 0; g < NUM_PP; g++) begin : g_pp
            mm_gf_mul #(.W(W), .POLY(POLY)) u_mul (
                .x(lhs[g]),
                .y(rhs[g]),
                .p(pp[g])
            );
        end
    endgenerate

    // Balanced two-level fold: every XOR at a level has equal-depth inputs.
    logic [W-1:0] lvl_cross;
    logic [W-1:0] lvl_mask;
    assign lvl_cross = pp[PP_BMA] ^ pp[PP_AMB];
    assign lvl_mask  = pp[PP_MM]  ^ pp[PP_Q1];
    assign t_folded  = lvl_cross ^ lvl_mask;
    assign t_direct  = pp[PP_AB];
endmodule

// File: rtl/mm_mid_stage.sv
`timescale 1ns/1ps
module mm_mid_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] direct_i,
    input  logic [W-1:0] folded_i,
    output logic         vld_o,
    output logic [W-1:0] direct_o,
    output logic [W-1:0] folded_o
);
    // Falling edge: re-aligns the two unequal-depth terms half a period on.
    always_ff @(negedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            direct_o <= '0;
            folded_o <= '0;
        end else begin
            vld_o    <= vld_i;
            direct_o <= direct_i;
            folded_o <= folded_i;
        end
    end
endmodule

// File: rtl/masked_gf_mult.sv
`timescale 1ns/1ps
module masked_gf_mult import mgm_pkg::*; #(
    parameter int             W    = 4,
    parameter logic [MAX_W:0] POLY = 9'h013
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] am,
    input  logic [W-1:0] ma,
    input  logic [W-1:0] bm,
    input  logic [W-1:0] mb,
    input  logic [W-1:0] mq,
    output logic         out_valid,
    output logic [W-1:0] qm
);
    logic         s_vld;
    logic [W-1:0] s_am, s_ma, s_bm, s_mb, s_mq;
    logic [W-1:0] t_direct, t_folded;
    logic [W-1:0] h_direct, h_folded;

    mm_in_stage #(.W(W)) u_in (
        .clk  (clk),
        .rst  (rst),
        .vld_i(in_valid),
        .am_i (am),
        .ma_i (ma),
        .bm_i (bm),
        .mb_i (mb),
        .mq_i (mq),
        .vld_o(s_vld),
        .am_o (s_am),
        .ma_o (s_ma),
        .bm_o (s_bm),
        .mb_o (s_mb),
        .mq_o (s_mq)
    );

    mm_pp_tree #(.W(W), .POLY(POLY)) u_tree (
        .am      (s_am),
        .ma      (s_ma),
        .bm      (s_bm),
        .mb      (s_mb),
        .mq      (s_mq),
        .t_direct(t_direct),
        .t_folded(t_folded)
    );

    mm_mid_stage #(.W(W)) u_mid (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (s_vld),
        .direct_i(t_direct),
        .folded_i(t_folded),
        .vld_o   (out_valid),
        .direct_o(h_direct),
        .folded_o(h_folded)
    );

    assign qm = h_direct ^ h_folded;

    // R1: the two tree outputs recombine to the masked true product.
    logic [MAX_W-1:0] ref_full;
    assign ref_full = gf_mul(MAX_W'(s_am ^ s_ma), MAX_W'(s_bm ^ s_mb), POLY, W);

    p_recombine_r1: assert property (@(negedge clk) disable iff (rst)
        (t_direct ^ t_folded) == (ref_full[W-1:0] ^ s_mq));

    // R2: the output shows what the tree offered at the previous falling edge.
    p_mid_capture_r2: assert property (@(negedge clk) disable iff (rst)
        !rst |=> (qm == $past(t_direct ^ t_folded)));

    // R3: the valid flag rides along with the data.
    p_valid_track_r3: assert property (@(negedge clk) disable iff (rst)
        !rst |=> (out_valid == $past(s_vld)));

    // R4: leaving reset, the output stage is cleared.
    p_reset_clear_r4: assert property (@(negedge clk) disable iff (rst)
        $fell(rst) |-> (qm == '0 && !out_valid));

    // R6: a zero true operand leaves only the fresh mask.
    p_zero_a_r6: assert property (@(negedge clk) disable iff (rst)
        (s_am == s_ma) |-> ((t_direct ^ t_folded) == s_mq));

endmodule

// File: tb/sim_masked_gf_mult.sv
`timescale 1ns/1ps
module sim_masked_gf_mult;
    localparam int W = 4;
    localparam int POLY_I = 'h13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] am = '0, ma = '0, bm = '0, mb = '0, mq = '0;
    logic         out_valid;
    logic [W-1:0] qm;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [W-1:0] prev_q = '0;
    logic         prev_v = 1'b0;

    always #10 clk = ~clk;

    masked_gf_mult #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .am(am), .ma(ma), .bm(bm), .mb(mb), .mq(mq),
        .out_valid(out_valid), .qm(qm)
    );

    // Carry-less product followed by polynomial reduction.
    function automatic int ref_mul(input int x, input int y);
        int prod = 0;
        for (int i = 0; i < W; i++)
            if ((y >> i) & 1) prod = prod ^ (x << i);
        for (int d = 2*W-2; d >= W; d--)
            if ((prod >> d) & 1) prod = prod ^ (POLY_I << (d - W));
        return prod & ((1 << W) - 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one operand set, check the hold window and then the new result.
    task automatic run_vec(input logic v, input logic [W-1:0] a_m, input logic [W-1:0] a_k,
                           input logic [W-1:0] b_m, input logic [W-1:0] b_k,
                           input logic [W-1:0] q_k, input string req);
        int exp_q;
        in_valid = v; am = a_m; ma = a_k; bm = b_m; mb = b_k; mq = q_k;
        exp_q = ref_mul(int'(a_m ^ a_k), int'(b_m ^ b_k)) ^ int'(q_k);
        @(posedge clk);
        #2;
        chk("R2 hold", int'(qm), int'(prev_q));
        chk("R3 hold", int'(out_valid), int'(prev_v));
        #13;
        chk(req, int'(qm), exp_q);
        chk("R3", int'(out_valid), int'(v));
        prev_q = W'(exp_q);
        prev_v = v;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r5_a;
        logic [W-1:0] r5_b;
        // R4: reset with busy inputs keeps everything cleared
        in_valid = 1'b1; am = 4'h7; ma = 4'h2; bm = 4'h9; mb = 4'h4; mq = 4'hC;
        repeat (3) @(posedge clk);
        #15;
        chk("R4 qm", int'(qm), 0);
        chk("R4 valid", int'(out_valid), 0);
        rst = 1'b0;
        prev_q = '0; prev_v = 1'b0;

        // R1 directed patterns
        run_vec(1'b1, 4'h3, 4'h0, 4'h5, 4'h0, 4'h0, "R1 unmasked");
        run_vec(1'b1, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, "R1 all-ones");
        run_vec(1'b1, 4'hA, 4'h6, 4'h1, 4'hD, 4'h9, "R1 masked");
        // R6: true a = 0
        run_vec(1'b1, 4'hB, 4'hB, 4'h7, 4'h3, 4'h5, "R6");
        run_vec(1'b0, 4'h4, 4'h4, 4'hE, 4'h1, 4'hA, "R6");
        // R7: true a = 1
        run_vec(1'b1, 4'h8, 4'h9, 4'h6, 4'h0, 4'h3, "R7");
        run_vec(1'b1, 4'h2, 4'h3, 4'hC, 4'h5, 4'hF, "R7");

        // R5: same a=5, b=9 under two mask sets
        run_vec(1'b1, 4'h5 ^ 4'h3, 4'h3, 4'h9 ^ 4'hA, 4'hA, 4'h6, "R5 first");
        r5_a = qm ^ 4'h6;
        run_vec(1'b1, 4'h5 ^ 4'hE, 4'hE, 4'h9 ^ 4'h1, 4'h1, 4'hB, "R5 second");
        r5_b = qm ^ 4'hB;
        chk("R5 mask independence", int'(r5_b), int'(r5_a));

        // R1/R3 random traffic
        for (int n = 0; n < 300; n++)
            run_vec(1'($urandom), W'($urandom), W'($urandom), W'($urandom),
                    W'($urandom), W'($urandom), "R1 random");

        // R4: reset raised mid-stream
        rst = 1'b1;
        @(posedge clk);
        #15;
        chk("R4 mid qm", int'(qm), 0);
        chk("R4 mid valid", int'(out_valid), 0);
        rst = 1'b0;
        prev_q = '0; prev_v = 1'b0;

        for (int n = 0; n < 100; n++)
            run_vec(1'b1, W'($urandom), W'($urandom), W'($urandom),
                    W'($urandom), W'($urandom), "R1 after reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule